// File: doc/BRIEF.md
# Slot-Driven Video DMA Engine

This block moves data into a video controller's write queue on behalf of the host. The controller splits each scan line into numbered access slots. On every slot strobe the engine may place at most one entry on the queue's push port. Each entry carries a target address, a data word, an access code, a one-byte marker and a ready time. The queue and the three video memories live outside the block. The block only reads the memories through synchronous read ports and reads an external bus through a port of the same kind.

The two top bits of the high source register select how the engine gets its data. In bus transfer mode it reads words from the external bus. In copy mode it reads from the same memory the access code targets. In fill mode it repeats the value the host wrote most recently.

The control port loads the source, length, address, auto-increment and access-code registers with a one-cycle pulse. Bus transfer and copy start from that pulse. Fill is armed by the pulse and starts on the host's next data write. The engine advances its own registers after each push and goes idle when the length runs out.

Top module: `vdma_engine`

## Requirements
- R1: Bits 7:6 of the high source register select the mode. 00 and 01 select bus transfer, 10 selects fill and 11 selects copy. A configuration load starts bus transfer or copy only when bit 5 (start) of the access code is set, and it never starts fill.
- R2: While running, an accepted slot produces exactly one push, visible two clock edges after the edge that samples the slot strobe. No push comes from a slot whose refresh flag is set, or while the queue reports full.
- R3: In bus transfer mode a slot is skipped when the previous strobed slot was a refresh slot, except that slot index 0 always proceeds. The bus read address is {high, middle, low} source, and the bus word is pushed unmarked.
- R4: In copy mode a slot proceeds only when the unused-slot flag is set. The engine then pulses unused_clr in the same cycle as the push. The low nibble of the access code selects the source memory: 1 is pattern RAM, read at {middle, low}; 3 is colour RAM, read at the low source bits masked to its size; 5 is scroll RAM, read at the same kind of masked index. A scroll index at or above the scroll depth reads as 0.
- R5: In fill mode the pushed value is the last accepted host word. When the access code targets pattern RAM (nibble 1), only its high byte is pushed, in bits 7:0. Fill entries are always marked as single-byte.
- R6: Every entry's ready time is the time sampled with the slot plus three slot periods.
- R7: After each push, the low source register increments and carries into the middle register only. The address grows by the auto-increment value, and the 16-bit length decrements.
- R8: When the decremented length reaches zero, busy falls and bit 5 of the access code is cleared. The last entry still carries the code with bit 5 set.
- R9: A host data write while a bus transfer or copy is running is rejected: host_reject pulses one cycle later. A write is ignored when bit 0 of the access code is clear.
- R10: An accepted host write records its value and advances the address by the auto-increment. When bit 5 is set and the mode is fill, the write starts the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load pulse for the register set (ignored while busy) |
| cfg_src_hi | input | 8 | High source register; bits 7:6 select the mode |
| cfg_src_mid | input | 8 | Middle source register |
| cfg_src_lo | input | 8 | Low source register |
| cfg_len | input | 16 | Transfer length in entries |
| cfg_addr | input | 16 | Destination address |
| cfg_code | input | 6 | Access code (bit 5 start, bit 0 write, 3:0 target) |
| cfg_inc | input | 8 | Auto-increment value |
| host_wr | input | 1 | Host data write strobe |
| host_data | input | 16 | Host data word |
| host_reject | output | 1 | Host write was refused (registered pulse) |
| busy | output | 1 | Engine running |
| slot_go | input | 1 | Access slot strobe |
| slot_idx | input | 9 | Index of the strobed slot |
| slot_refresh | input | 1 | Strobed slot is a refresh slot |
| slot_unused | input | 1 | Strobed slot is marked unused |
| unused_clr | output | 1 | Consumes the unused-slot flag |
| fifo_full | input | 1 | Write queue full |
| now_time | input | 20 | Current time |
| slot_period | input | 8 | Length of one slot period in time units |
| bus_addr | output | 24 | External bus read address |
| bus_rdata | input | 16 | External bus data, one cycle after the address |
| pat_raddr | output | 16 | Pattern RAM byte read address |
| pat_rdata | input | 8 | Pattern RAM data, one cycle latency |
| col_raddr | output | 6 | Colour RAM read index |
| col_rdata | input | 16 | Colour RAM data, one cycle latency |
| scr_raddr | output | 6 | Scroll RAM read index |
| scr_rdata | input | 16 | Scroll RAM data, one cycle latency |
| push | output | 1 | Queue push strobe |
| push_addr | output | 16 | Entry address |
| push_data | output | 16 | Entry data |
| push_code | output | 6 | Entry access code |
| push_partial | output | 1 | Entry is a single-byte write |
| push_ready | output | 20 | Entry ready time |

## Verification
The refresh-adjacent skip is the hardest case to reach. It only shows when a refresh slot and the strobe that follows it both arrive during a bus transfer, and the exception for slot index 0 needs that same pairing with a zero index. The bench drives slot strobes one at a time with chosen index and flag values. It strobes a refresh slot, then a normal slot, then a third slot, and checks that only the third pushes. It repeats the sequence with index 0 in the second position. Copy reads past the scroll depth, and a length that ends exactly as the low source wraps, are reached by loading source values just below those boundaries.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [1:0] MODE_FILL = 2'b10;
  localparam logic [1:0] MODE_COPY = 2'b11;
  localparam logic [3:0] TGT_PAT = 4'h1;
  localparam logic [3:0] TGT_COL = 4'h3;
  localparam logic [3:0] TGT_SCR = 4'h5;
  localparam int START_BIT = 5;
  localparam int WRITE_BIT = 0;

  function automatic logic is_fill(input logic [7:0] hi);
    return hi[7:6] == MODE_FILL;
  endfunction

  function automatic logic is_copy(input logic [7:0] hi);
    return hi[7:6] == MODE_COPY;
  endfunction

  function automatic logic is_bus(input logic [7:0] hi);
    return hi[7] == 1'b0;
  endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 16,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [7:0]    cfg_src_hi,
  input  logic [7:0]    cfg_src_mid,
  input  logic [7:0]    cfg_src_lo,
  input  logic [LW-1:0] cfg_len,
  input  logic [AW-1:0] cfg_addr,
  input  logic [5:0]    cfg_code,
  input  logic [IW-1:0] cfg_inc,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  input  logic          adv,
  output logic [7:0]    src_hi,
  output logic [7:0]    src_mid,
  output logic [7:0]    src_lo,
  output logic [AW-1:0] addr,
  output logic [5:0]    code,
  output logic [DW-1:0] last_val,
  output logic          busy,
  output logic          host_reject
);
  logic [LW-1:0] len;
  logic [IW-1:0] inc;
  logic          fill_mode;
  logic          blocked;
  logic          host_ok;
  logic          last_step;
  logic [AW-1:0] step_a;
  logic [AW-1:0] step_h;

  assign fill_mode = is_fill(src_hi);
  assign blocked   = busy && !fill_mode;
  assign host_ok   = host_wr && !blocked && code[WRITE_BIT];
  assign last_step = adv && (len == LW'(1));
  assign step_a    = adv ? AW'(inc) : '0;
  assign step_h    = host_ok ? AW'(inc) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_hi      <= '0;
      src_mid     <= '0;
      src_lo      <= '0;
      len         <= '0;
      addr        <= '0;
      code        <= '0;
      inc         <= '0;
      last_val    <= '0;
      busy        <= 1'b0;
      host_reject <= 1'b0;
    end else begin
      host_reject <= host_wr && blocked;
      if (cfg_load && !busy) begin
        src_hi  <= cfg_src_hi;
        src_mid <= cfg_src_mid;
        src_lo  <= cfg_src_lo;
        len     <= cfg_len;
        addr    <= cfg_addr;
        code    <= cfg_code;
        inc     <= cfg_inc;
        busy    <= cfg_code[START_BIT] && !is_fill(cfg_src_hi);
      end else begin
        addr <= addr + step_a + step_h;
        if (adv) begin
          src_lo <= src_lo + 8'd1;
          if (src_lo == 8'hFF) src_mid <= src_mid + 8'd1;
          len <= len - LW'(1);
          if (last_step) begin
            busy            <= 1'b0;
            code[START_BIT] <= 1'b0;
          end
        end
        if (host_ok) begin
          last_val <= host_data;
          if (code[START_BIT] && fill_mode) busy <= 1'b1;
        end
      end
    end
  end

  // R8: the run only ends on the final push
  assert_stop_on_last_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(adv));
  // R9: refusals only while a non-fill run is active
  assert_reject_cause_R9: assert property (@(posedge clk) disable iff (rst)
    host_reject |-> $past(busy && !is_fill(src_hi)));
  // R1: a load never starts a fill
  assert_fill_not_by_load_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_load && !busy && !host_wr) && is_fill(src_hi)) |-> !busy);
endmodule

// File: rtl/vdma_gate.sv
module vdma_gate
  import vdma_pkg::*;
#(
  parameter int SW = 9,
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_go,
  input  logic [SW-1:0] slot_idx,
  input  logic          slot_refresh,
  input  logic          slot_unused,
  input  logic          fifo_full,
  input  logic          busy,
  input  logic [7:0]    src_hi,
  input  logic [TW-1:0] now_time,
  output logic          pend,
  output logic [TW-1:0] when_q
);
  logic prev_ref;
  logic mode_ok;
  logic take;

  always_comb begin
    if (is_bus(src_hi))       mode_ok = (slot_idx == '0) || !prev_ref;
    else if (is_copy(src_hi)) mode_ok = slot_unused;
    else                      mode_ok = 1'b1;
  end

  assign take = slot_go && busy && !pend && !slot_refresh && !fifo_full && mode_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ref <= 1'b0;
      pend     <= 1'b0;
      when_q   <= '0;
    end else begin
      if (slot_go) prev_ref <= slot_refresh;
      pend <= take;
      if (take) when_q <= now_time;
    end
  end

  // R2: a slot is only taken from a strobe outside refresh with queue space
  assert_take_clean_R2: assert property (@(posedge clk) disable iff (rst)
    pend |-> $past(slot_go && !slot_refresh && !fifo_full));
  // R4: copy takes only unused slots
  assert_copy_unused_R4: assert property (@(posedge clk) disable iff (rst)
    (pend && is_copy(src_hi)) |-> $past(slot_unused));
endmodule

// File: rtl/vdma_src.sv
module vdma_src
  import vdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 20,
  parameter int PW = 8,
  parameter int COL_DEPTH = 64,
  parameter int SCR_DEPTH = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  logic [TW-1:0] when_q,
  input  logic [PW-1:0] slot_period,
  input  logic [7:0]    src_hi,
  input  logic [7:0]    src_mid,
  input  logic [7:0]    src_lo,
  input  logic [AW-1:0] addr,
  input  logic [5:0]    code,
  input  logic [DW-1:0] last_val,
  output logic [23:0]   bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [15:0]   pat_raddr,
  input  logic [7:0]    pat_rdata,
  output logic [$clog2(COL_DEPTH)-1:0] col_raddr,
  input  logic [DW-1:0] col_rdata,
  output logic [$clog2(SCR_DEPTH)-1:0] scr_raddr,
  input  logic [DW-1:0] scr_rdata,
  output logic          push,
  output logic [AW-1:0] push_addr,
  output logic [DW-1:0] push_data,
  output logic [5:0]    push_code,
  output logic          push_partial,
  output logic [TW-1:0] push_ready,
  output logic          unused_clr
);
  localparam int CAW = $clog2(COL_DEPTH);
  localparam int VAW = $clog2(SCR_DEPTH);

  logic [DW-1:0] val;
  logic          partial;
  logic [TW-1:0] lat;
  logic          scr_oob;

  assign bus_addr  = {src_hi, src_mid, src_lo};
  assign pat_raddr = {src_mid, src_lo};
  assign col_raddr = src_lo[CAW-1:0];
  assign scr_raddr = src_lo[VAW-1:0];
  assign scr_oob   = int'(src_lo[VAW-1:0]) >= SCR_DEPTH;
  assign lat       = TW'(slot_period) + TW'(slot_period) + TW'(slot_period);

  always_comb begin
    val     = bus_rdata;
    partial = 1'b0;
    if (is_fill(src_hi)) begin
      partial = 1'b1;
      val     = (code[3:0] == TGT_PAT) ? DW'(last_val[DW-1 -: 8]) : last_val;
    end else if (is_copy(src_hi)) begin
      case (code[3:0])
        TGT_PAT: val = DW'(pat_rdata);
        TGT_COL: val = col_rdata;
        TGT_SCR: val = scr_oob ? '0 : scr_rdata;
        default: val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      push         <= 1'b0;
      push_addr    <= '0;
      push_data    <= '0;
      push_code    <= '0;
      push_partial <= 1'b0;
      push_ready   <= '0;
      unused_clr   <= 1'b0;
    end else begin
      push       <= pend;
      unused_clr <= pend && is_copy(src_hi);
      if (pend) begin
        push_addr    <= addr;
        push_data    <= val;
        push_code    <= code;
        push_partial <= partial;
        push_ready   <= when_q + lat;
      end
    end
  end

  // R5: every fill entry is single-byte, bus and copy entries are not
  assert_fill_partial_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_partial == $past(is_fill(src_hi))));
  // R4: the unused flag is consumed together with a push
  assert_clr_with_push_R4: assert property (@(posedge clk) disable iff (rst)
    unused_clr |-> push);
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 16,
  parameter int IW = 8,
  parameter int SW = 9,
  parameter int TW = 20,
  parameter int PW = 8,
  parameter int COL_DEPTH = 64,
  parameter int SCR_DEPTH = 40,
  localparam int CAW = $clog2(COL_DEPTH),
  localparam int VAW = $clog2(SCR_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_load,
  input  logic [7:0]     cfg_src_hi,
  input  logic [7:0]     cfg_src_mid,
  input  logic [7:0]     cfg_src_lo,
  input  logic [LW-1:0]  cfg_len,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [5:0]     cfg_code,
  input  logic [IW-1:0]  cfg_inc,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_data,
  output logic           host_reject,
  output logic           busy,
  input  logic           slot_go,
  input  logic [SW-1:0]  slot_idx,
  input  logic           slot_refresh,
  input  logic           slot_unused,
  output logic           unused_clr,
  input  logic           fifo_full,
  input  logic [TW-1:0]  now_time,
  input  logic [PW-1:0]  slot_period,
  output logic [23:0]    bus_addr,
  input  logic [DW-1:0]  bus_rdata,
  output logic [15:0]    pat_raddr,
  input  logic [7:0]     pat_rdata,
  output logic [CAW-1:0] col_raddr,
  input  logic [DW-1:0]  col_rdata,
  output logic [VAW-1:0] scr_raddr,
  input  logic [DW-1:0]  scr_rdata,
  output logic           push,
  output logic [AW-1:0]  push_addr,
  output logic [DW-1:0]  push_data,
  output logic [5:0]     push_code,
  output logic           push_partial,
  output logic [TW-1:0]  push_ready
);
  logic [7:0]    src_hi, src_mid, src_lo;
  logic [AW-1:0] addr;
  logic [5:0]    code;
  logic [DW-1:0] last_val;
  logic          pend;
  logic [TW-1:0] when_q;

  vdma_regs #(.AW(AW), .DW(DW), .LW(LW), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_src_hi(cfg_src_hi), .cfg_src_mid(cfg_src_mid), .cfg_src_lo(cfg_src_lo),
    .cfg_len(cfg_len), .cfg_addr(cfg_addr), .cfg_code(cfg_code), .cfg_inc(cfg_inc),
    .host_wr(host_wr), .host_data(host_data), .adv(pend),
    .src_hi(src_hi), .src_mid(src_mid), .src_lo(src_lo), .addr(addr),
    .code(code), .last_val(last_val), .busy(busy), .host_reject(host_reject)
  );

  vdma_gate #(.SW(SW), .TW(TW)) u_gate (
    .clk(clk), .rst(rst), .slot_go(slot_go), .slot_idx(slot_idx),
    .slot_refresh(slot_refresh), .slot_unused(slot_unused), .fifo_full(fifo_full),
    .busy(busy), .src_hi(src_hi), .now_time(now_time), .pend(pend), .when_q(when_q)
  );

  vdma_src #(.AW(AW), .DW(DW), .TW(TW), .PW(PW),
             .COL_DEPTH(COL_DEPTH), .SCR_DEPTH(SCR_DEPTH)) u_src (
    .clk(clk), .rst(rst), .pend(pend), .when_q(when_q), .slot_period(slot_period),
    .src_hi(src_hi), .src_mid(src_mid), .src_lo(src_lo), .addr(addr), .code(code),
    .last_val(last_val), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pat_raddr(pat_raddr), .pat_rdata(pat_rdata), .col_raddr(col_raddr),
    .col_rdata(col_rdata), .scr_raddr(scr_raddr), .scr_rdata(scr_rdata),
    .push(push), .push_addr(push_addr), .push_data(push_data), .push_code(push_code),
    .push_partial(push_partial), .push_ready(push_ready), .unused_clr(unused_clr)
  );

  // R2: pushes only come from a running engine
  assert_push_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(busy, 2));
  // R2: at most one push per taken slot, never back to back
  assert_single_push_R2: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);
endmodule

// File: tb/sim_vdma_engine.sv
module sim_vdma_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cfg_load = 0; logic [7:0] cfg_src_hi = 0, cfg_src_mid = 0, cfg_src_lo = 0;
  logic [15:0] cfg_len = 0, cfg_addr = 0; logic [5:0] cfg_code = 0; logic [7:0] cfg_inc = 0;
  logic host_wr = 0; logic [15:0] host_data = 0; logic host_reject, busy;
  logic slot_go = 0; logic [8:0] slot_idx = 0; logic slot_refresh = 0, slot_unused = 0;
  logic unused_clr; logic fifo_full = 0; logic [19:0] now_time = 0; logic [7:0] slot_period = 16;
  logic [23:0] bus_addr; logic [15:0] bus_rdata, pat_raddr; logic [7:0] pat_rdata;
  logic [5:0] col_raddr, scr_raddr; logic [15:0] col_rdata, scr_rdata;
  logic push, push_partial; logic [15:0] push_addr, push_data; logic [5:0] push_code;
  logic [19:0] push_ready;

  int total = 0, bad = 0;

  function automatic logic [15:0] bus_f(input logic [23:0] a);  return a[15:0] ^ 16'hA5C3; endfunction
  function automatic logic [7:0]  pat_f(input logic [15:0] a);  return a[7:0] ^ a[15:8] ^ 8'h3C; endfunction
  function automatic logic [15:0] col_f(input logic [5:0] i);   return {8'hC0, 2'b00, i}; endfunction
  function automatic logic [15:0] scr_f(input logic [5:0] i);   return {8'h5A, 2'b00, i}; endfunction

  always_ff @(posedge clk) begin
    bus_rdata <= bus_f(bus_addr);
    pat_rdata <= pat_f(pat_raddr);
    col_rdata <= col_f(col_raddr);
    scr_rdata <= scr_f(scr_raddr);
  end

  vdma_engine u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] hi, mid, lo, input logic [15:0] len, ad,
                      input logic [5:0] cd, input logic [7:0] inc);
    @(negedge clk);
    cfg_src_hi = hi; cfg_src_mid = mid; cfg_src_lo = lo; cfg_len = len;
    cfg_addr = ad; cfg_code = cd; cfg_inc = inc; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  // pulses one slot and returns at the negedge where its push is visible
  task automatic slot(input logic [8:0] idx, input logic rf, un, full);
    @(negedge clk);
    slot_go = 1; slot_idx = idx; slot_refresh = rf; slot_unused = un; fifo_full = full;
    @(negedge clk); slot_go = 0; slot_refresh = 0; slot_unused = 0; fifo_full = 0;
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_data = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic t_reset;
    chk("R2", "push after reset", push, 0);
    chk("R8", "busy after reset", busy, 0);
    chk("R9", "reject after reset", host_reject, 0);
  endtask

  task automatic t_bus;
    now_time = 20'd1000; slot_period = 8'd16;
    load(8'h41, 8'hFF, 8'hFE, 16'd3, 16'h0100, 6'h21, 8'd2);
    chk("R1", "bus start", busy, 1);
    slot(9'd5, 0, 0, 0);
    chk("R3", "push 1", push, 1);
    chk("R3", "data 1", push_data, bus_f(24'h41FFFE));
    chk("R3", "unmarked", push_partial, 0);
    chk("R6", "ready", push_ready, 20'd1048);
    chk("R7", "addr 1", push_addr, 16'h0100);
    chk("R7", "src after 1", bus_addr, 24'h41FFFF);
    slot(9'd6, 0, 0, 0);
    chk("R7", "addr 2", push_addr, 16'h0102);
    chk("R7", "carry mid only", bus_addr, 24'h410000);
    slot(9'd7, 0, 0, 0);
    chk("R3", "data 3", push_data, bus_f(24'h410000));
    chk("R8", "last code keeps start", push_code, 6'h21);
    chk("R8", "busy falls", busy, 0);
    slot(9'd8, 0, 0, 0);
    chk("R8", "no push idle", push, 0);
  endtask

  task automatic t_refresh;
    load(8'h00, 8'h10, 8'h20, 16'd2, 16'h0000, 6'h21, 8'd2);
    slot(9'd10, 1, 0, 0);
    chk("R2", "refresh slot idle", push, 0);
    slot(9'd11, 0, 0, 0);
    chk("R3", "after refresh skipped", push, 0);
    slot(9'd12, 0, 0, 0);
    chk("R3", "next slot pushes", push, 1);
    slot(9'd40, 1, 0, 0);
    slot(9'd0, 0, 0, 0);
    chk("R3", "slot 0 proceeds", push, 1);
    chk("R3", "slot 0 data", push_data, bus_f(24'h001021));
    chk("R8", "done", busy, 0);
  endtask

  task automatic t_full_reject;
    load(8'h00, 8'h00, 8'h00, 16'd1, 16'h0040, 6'h21, 8'd2);
    slot(9'd3, 0, 0, 1);
    chk("R2", "full blocks", push, 0);
    chk("R2", "still busy", busy, 1);
    @(negedge clk); host_wr = 1; host_data = 16'h1111;
    @(negedge clk); host_wr = 0;
    chk("R9", "reject during bus", host_reject, 1);
    slot(9'd4, 0, 0, 0);
    chk("R9", "rejected write left addr", push_addr, 16'h0040);
  endtask

  task automatic t_copy;
    load(8'hC0, 8'h34, 8'h56, 16'd1, 16'h0300, 6'h21, 8'd1);
    slot(9'd5, 0, 0, 0);
    chk("R4", "copy waits unused", push, 0);
    slot(9'd6, 0, 1, 0);
    chk("R4", "copy pat", push_data, {8'h00, pat_f(16'h3456)});
    chk("R4", "clr with push", unused_clr, 1);
    load(8'hC0, 8'h00, 8'h45, 16'd1, 16'h0000, 6'h23, 8'd2);
    slot(9'd7, 0, 1, 0);
    chk("R4", "copy col masked", push_data, col_f(6'd5));
    load(8'hC0, 8'h00, 8'h27, 16'd2, 16'h0000, 6'h25, 8'd2);
    slot(9'd8, 0, 1, 0);
    chk("R4", "copy scr in range", push_data, scr_f(6'd39));
    slot(9'd9, 0, 1, 0);
    chk("R4", "copy scr oob", push_data, 16'h0000);
    chk("R8", "copy done", busy, 0);
  endtask

  task automatic t_fill;
    load(8'h80, 8'h00, 8'h00, 16'd2, 16'h0200, 6'h21, 8'd1);
    chk("R1", "fill not by load", busy, 0);
    hwrite(16'hBEEF);
    chk("R10", "host write starts fill", busy, 1);
    slot(9'd5, 0, 0, 0);
    chk("R10", "addr advanced by write", push_addr, 16'h0201);
    chk("R5", "pat high byte", push_data, 16'h00BE);
    chk("R5", "marked", push_partial, 1);
    slot(9'd6, 0, 0, 0);
    chk("R7", "fill addr 2", push_addr, 16'h0202);
    chk("R8", "fill done", busy, 0);
    hwrite(16'h1234);
    chk("R8", "start bit cleared", busy, 0);
    load(8'h80, 8'h00, 8'h00, 16'd1, 16'h0010, 6'h23, 8'd2);
    hwrite(16'h0ABC);
    slot(9'd7, 0, 0, 0);
    chk("R5", "col full word", push_data, 16'h0ABC);
    chk("R10", "col addr", push_addr, 16'h0012);
    load(8'h80, 8'h00, 8'h00, 16'd1, 16'h0000, 6'h20, 8'd2);
    hwrite(16'h5555);
    chk("R9", "read code ignores write", busy, 0);
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_bus();
    t_refresh();
    t_full_reject();
    t_copy();
    t_fill();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule